// File: doc/BRIEF.md
# Sync Pulse Gating Controller

This block takes one external synchronization pulse and hands it to two downstream consumers: a signal-monitor path and a clock-divider path. The external input is first brought into the system clock domain by a short flop chain. A rising edge on the synchronized level then becomes a single-cycle internal pulse. Each consumer gets its own registered, gated copy of that pulse. Whether a copy is passed depends on an 8-bit control word, which is written and read back through a simple register port.

A global enable must be set before either consumer sees anything. A per-consumer enable then selects which paths pass pulses. By default every qualifying pulse is forwarded, which is continuous operation. When the one-shot bit is set, the divider path takes only the next qualifying pulse. The block then clears its own divider enable, so every later pulse is held off until software sets that enable again. The monitor path is not affected by the one-shot bit. The read-back port lets software see when the self-clear has happened.

Control word layout: bit 0 is the global enable, bit 1 is the divider enable, bit 2 is the one-shot select and bit 7 is the monitor enable. Bits 6 to 3 are unused.

Top module: `sync_gate_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, both gated outputs are 0 and the control read-back is 8'h00.
- R2: With bit 0 of the control word clear, no input edge produces a pulse on either output, whatever the other bits hold.
- R3: With bits 0 and 7 set, a rising input edge driven before clock edge k makes the monitor output high for exactly one cycle, starting at clock edge k+2.
- R4: With bits 0 and 1 set and bit 2 clear, every rising input edge produces one divider pulse. The timing is the same as for the monitor output.
- R5: With bits 0, 1 and 2 set, the first rising edge produces a divider pulse. At the same clock edge that raises the pulse, bit 1 of the read-back becomes 0, and later edges produce no divider pulse.
- R6: A register write that lands on the same clock edge as a self-clear wins, and the read-back equals the written value with the unused bits forced to 0.
- R7: Bits 6 to 3 of the read-back are always 0, even after writing 1s to them.
- R8: An input held high for many cycles produces only one pulse on each enabled output.
- R9: The one-shot bit has no effect on the monitor output: the monitor output keeps passing pulses after the divider enable has cleared itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_sync_i | input | 1 | External sync level, asynchronous to clk |
| cfg_wr_i | input | 1 | Control-word write strobe |
| cfg_wdata_i | input | 8 | Control-word write data |
| cfg_rdata_o | output | 8 | Current control word, unused bits zero |
| mon_sync_o | output | 1 | Gated pulse for the signal monitor |
| div_sync_o | output | 1 | Gated pulse for the clock divider |

## Verification
A change on the external input is due at the gated outputs three clock edges later: two synchronizer flops, and then the output register fed by the edge detector. The pulse lasts one cycle, so the bench drives inputs on the falling edge and samples at the following falling edges. It either counts pulses over a window wider than that latency, or looks at the exact third edge. A control write is visible on the read-back after one edge. The self-clear lands on the same edge as the divider pulse, so the read-back is sampled in the same half-cycle as that pulse. In the write-priority case, the write is placed in the half-cycle just before the third edge.

// File: rtl/sync_gate_pkg.sv
package sync_gate_pkg;

    localparam int CFG_W = 8;

    typedef struct packed {
        logic       mon_en;
        logic [3:0] unused;
        logic       one_shot;
        logic       div_en;
        logic       master;
    } cfg_t;

    localparam logic [CFG_W-1:0] CFG_LIVE_MASK = 8'h87;

    typedef struct packed {
        logic mon;
        logic div;
    } gate_t;

endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/sync_cfg_reg.sv
module sync_cfg_reg
    import sync_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CFG_W-1:0] wdata_i,
    input  logic             self_clr_i,
    output cfg_t             cfg_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            cfg_d = cfg_t'(wdata_i & CFG_LIVE_MASK);
        end else if (self_clr_i) begin
            cfg_d.div_en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/sync_gate_ctrl.sv
module sync_gate_ctrl
    import sync_gate_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_sync_i,
    input  logic             cfg_wr_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic [CFG_W-1:0] cfg_rdata_o,
    output logic             mon_sync_o,
    output logic             div_sync_o
);
    logic  rise;
    logic  self_clr;
    cfg_t  cfg;
    gate_t gate_d, gate_q;

    sync_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_sync_i),
        .rise_o  (rise)
    );

    sync_cfg_reg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (cfg_wr_i),
        .wdata_i    (cfg_wdata_i),
        .self_clr_i (self_clr),
        .cfg_o      (cfg)
    );

    always_comb begin
        gate_d.mon = rise & cfg.master & cfg.mon_en;
        gate_d.div = rise & cfg.master & cfg.div_en;
        self_clr   = gate_d.div & cfg.one_shot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end

    assign mon_sync_o  = gate_q.mon;
    assign div_sync_o  = gate_q.div;
    assign cfg_rdata_o = cfg;
endmodule

// File: rtl/sync_gate_ctrl_chk.sv
module sync_gate_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr_i,
    input logic [7:0] cfg_wdata_i,
    input logic [7:0] cfg_rdata_o,
    input logic       mon_sync_o,
    input logic       div_sync_o
);
    AST_MON_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        mon_sync_o |-> ($past(cfg_rdata_o[7]) && $past(cfg_rdata_o[0]))); // R3
    AST_DIV_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        div_sync_o |-> ($past(cfg_rdata_o[1]) && $past(cfg_rdata_o[0]))); // R4
    AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_rdata_o[0]) |-> (!mon_sync_o && !div_sync_o)); // R2
    AST_ONESHOT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sync_o && $past(cfg_rdata_o[2]) && !$past(cfg_wr_i)) |-> !cfg_rdata_o[1]); // R5
    AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_wr_i) |-> (cfg_rdata_o == ($past(cfg_wdata_i) & 8'h87))); // R6
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata_o[6:3] == 4'h0); // R7
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_sync_o || div_sync_o) |=> (!mon_sync_o && !div_sync_o)); // R8
endmodule

bind sync_gate_ctrl sync_gate_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .mon_sync_o  (mon_sync_o),
    .div_sync_o  (div_sync_o)
);

// File: tb/sync_gate_ctrl_bench.sv
module sync_gate_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_sync_i = 1'b0;
    logic       cfg_wr_i = 1'b0;
    logic [7:0] cfg_wdata_i = 8'h00;
    logic [7:0] cfg_rdata_o;
    logic       mon_sync_o, div_sync_o;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    sync_gate_ctrl u_sync_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_sync_i(ext_sync_i),
        .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i),
        .cfg_rdata_o(cfg_rdata_o), .mon_sync_o(mon_sync_o), .div_sync_o(div_sync_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk); cfg_wr_i = 1'b1; cfg_wdata_i = v;
        @(negedge clk); cfg_wr_i = 1'b0;
    endtask

    // drive an input pulse of hi cycles, count output pulses over hi+8 cycles
    task automatic pulse_count(input int hi, output int mc, output int dc);
        mc = 0; dc = 0;
        @(negedge clk); ext_sync_i = 1'b1;
        for (int i = 0; i < hi + 8; i++) begin
            @(negedge clk);
            if (i == hi - 1) ext_sync_i = 1'b0;
            mc += int'(mon_sync_o);
            dc += int'(div_sync_o);
        end
    endtask

    task automatic t_reset;
        #1;
        check("R1 mon in reset", mon_sync_o, 0);
        check("R1 div in reset", div_sync_o, 0);
        check("R1 cfg in reset", cfg_rdata_o, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 cfg after reset", cfg_rdata_o, 8'h00);
    endtask

    task automatic t_master_off;
        int mc, dc;
        write_cfg(8'h86);
        pulse_count(2, mc, dc);
        check("R2 mon blocked", mc, 0);
        check("R2 div blocked", dc, 0);
    endtask

    task automatic t_mon_latency;
        write_cfg(8'h81);
        @(negedge clk); ext_sync_i = 1'b1;
        @(negedge clk); check("R3 edge1", mon_sync_o, 0);
        @(negedge clk); check("R3 edge2", mon_sync_o, 0);
        @(negedge clk); check("R3 edge3 high", mon_sync_o, 1);
        check("R3 div off", div_sync_o, 0);
        @(negedge clk); check("R3 one cycle", mon_sync_o, 0);
        ext_sync_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_continuous;
        int mc, dc;
        write_cfg(8'h03);
        for (int k = 0; k < 3; k++) begin
            pulse_count(1 + k, mc, dc);
            check("R4 div each edge", dc, 1);
            check("R4 mon off", mc, 0);
        end
        check("R4 enable kept", cfg_rdata_o, 8'h03);
    endtask

    task automatic t_one_shot;
        int mc, dc;
        write_cfg(8'h87);
        @(negedge clk); ext_sync_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R5 first pulse", div_sync_o, 1);
        check("R5 cleared same edge", cfg_rdata_o, 8'h85);
        ext_sync_i = 1'b0;
        repeat (4) @(negedge clk);
        pulse_count(2, mc, dc);
        check("R5 later blocked", dc, 0);
        check("R9 monitor still passes", mc, 1);
    endtask

    task automatic t_wr_priority;
        write_cfg(8'h07);
        @(negedge clk); ext_sync_i = 1'b1;
        @(negedge clk);
        @(negedge clk); cfg_wr_i = 1'b1; cfg_wdata_i = 8'h07;
        @(negedge clk); cfg_wr_i = 1'b0;
        check("R6 pulse out", div_sync_o, 1);
        check("R6 write wins", cfg_rdata_o, 8'h07);
        ext_sync_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_unused;
        write_cfg(8'hFF);
        check("R7 unused zero", cfg_rdata_o, 8'h87);
        write_cfg(8'h78);
        check("R7 only unused written", cfg_rdata_o, 8'h00);
    endtask

    task automatic t_long_hold;
        int mc, dc;
        write_cfg(8'h83);
        pulse_count(40, mc, dc);
        check("R8 mon single", mc, 1);
        check("R8 div single", dc, 1);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_master_off();
        t_mon_latency();
        t_continuous();
        t_one_shot();
        t_wr_priority();
        t_unused();
        t_long_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule